// File: doc/BRIEF.md
# Nested-Loop Sequencer for a Bit-Serial Multiplier

This block issues the control strobes for a shift-and-add multiplier that works one bit at a time. A single start pulse begins a run. The run has two nested loops, each of `N_BITS` passes. Each pass of the inner loop adds a partial sum and shifts it into the high product half. When an inner loop completes, one step cycle moves the next multiplier bit into place and retires one finished product bit into the low half. The run takes N² accumulate cycles and N step cycles. It produces one result bit for every N+1 active cycles.

The controller holds one flop per active state: setup, inner and step. When none of these flops is set, the controller is idle. Two small wrapping counters track the loops. The inner counter advances on every accumulate cycle and is cleared by the step cycle. The outer counter is cleared in setup and advances on each step cycle. Each counter has a terminal flag that is raised at its last value. Every strobe is one state flop or an OR of state flops, so no strobe depends on an input in the same cycle. `N_BITS` must be at least 2. The datapath registers and the adder are outside the block.

Top module: `serial_mult_sequencer`

## Requirements
- R1: After a synchronous reset every output is 0. With no start, every output stays 0.
- R2: A start sampled while idle gives exactly one setup cycle in which all outputs are 0. The first accumulate cycle follows it.
- R3: An accumulate cycle raises a_shift, sum_sel and hi_shift and no other output. Accumulate cycles come in runs of exactly N_BITS consecutive cycles.
- R4: Each run of accumulate cycles is followed by exactly one step cycle. A step cycle raises b_shift, hi_shift, lo_shift and step_clr and no other output. If this is not the last step cycle, accumulate cycles follow it.
- R5: One operation produces N_BITS² accumulate cycles, N_BITS step cycles and N_BITS²+N_BITS hi_shift cycles.
- R6: done is high for exactly one cycle, the cycle after the final step cycle. All other outputs are 0 in that cycle.
- R7: A start that arrives while an operation is in progress has no effect on the strobe sequence.
- R8: A start sampled in the done cycle begins a new operation at once. Its setup cycle directly follows the done cycle.
- R9: Reset asserted during an operation aborts it. All outputs are 0 in the next cycle and stay 0 until a new start.
- R10: An accumulate cycle and a step cycle never coincide (a_shift and b_shift are never both 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| a_shift | output | 1 | Shift the multiplicand register |
| b_shift | output | 1 | Shift the multiplier register |
| hi_shift | output | 1 | Shift the high product half |
| lo_shift | output | 1 | Shift the low product half |
| sum_sel | output | 1 | Select the adder sum into the high half |
| step_clr | output | 1 | Clear strobe issued at each loop step |
| done | output | 1 | One-cycle completion flag |

## Verification
Two functions can fall in the same cycle: the done flag of one operation and the acceptance of the next start. The bench provokes this by holding start high for a whole operation. The done cycle is then also the cycle in which a new start is sampled, and the following cycle must be a setup cycle. The second operation's pattern is judged cycle by cycle against the same schedule, shifted by one run length. This is done for three operand widths at once, and the same stimulus also shows that a start arriving mid-operation is ignored.

// File: rtl/serial_mult_pkg.sv
package serial_mult_pkg;

  // Active states, one flop each; all clear means idle.
  typedef struct packed {
    logic setup;
    logic inner;
    logic step;
  } seq_state_t;

  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/loop_counter.sv
module loop_counter #(
  parameter int WIDTH = 2,
  parameter int LAST  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  output logic [WIDTH-1:0] cnt,
  output logic             tc
);

  localparam logic [WIDTH-1:0] LAST_V = WIDTH'(LAST);

  assign tc = (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (en)
      cnt <= tc ? '0 : cnt + 1'b1;
  end

  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tc && !clr) |=> (cnt == '0));

  // R5
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_V);

endmodule

// File: rtl/seq_onehot_fsm.sv
module seq_onehot_fsm
  import serial_mult_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       tc_inner,
  input  logic       tc_outer,
  output seq_state_t st,
  output logic       done
);

  logic       idle;
  seq_state_t st_n;
  logic       done_n;

  assign idle = !(st.setup || st.inner || st.step);

  always_comb begin
    st_n.setup = idle && start;
    st_n.inner = st.setup || (st.inner && !tc_inner) || (st.step && !tc_outer);
    st_n.step  = st.inner && tc_inner;
    done_n     = st.step && tc_outer;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= '0;
      done <= 1'b0;
    end else begin
      st   <= st_n;
      done <= done_n;
    end
  end

  // R10
  state_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st.setup, st.inner, st.step}));

  // R2
  setup_to_inner_chk: assert property (@(posedge clk) disable iff (rst)
    st.setup |=> st.inner);

  // R4
  step_return_chk: assert property (@(posedge clk) disable iff (rst)
    (st.step && !tc_outer) |=> (st.inner && !done));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> idle);

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !idle |=> !st.setup);

endmodule

// File: rtl/serial_mult_sequencer.sv
module serial_mult_sequencer
  import serial_mult_pkg::*;
#(
  parameter int N_BITS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic a_shift,
  output logic b_shift,
  output logic hi_shift,
  output logic lo_shift,
  output logic sum_sel,
  output logic step_clr,
  output logic done
);

  localparam int CW = cnt_width(N_BITS);

  seq_state_t    st;
  logic [CW-1:0] inner_cnt;
  logic [CW-1:0] outer_cnt;
  logic          tc_inner;
  logic          tc_outer;

  seq_onehot_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .tc_inner (tc_inner),
    .tc_outer (tc_outer),
    .st       (st),
    .done     (done)
  );

  loop_counter #(.WIDTH(CW), .LAST(N_BITS-1)) u_inner_ctr (
    .clk (clk),
    .rst (rst),
    .en  (st.inner),
    .clr (st.step),
    .cnt (inner_cnt),
    .tc  (tc_inner)
  );

  loop_counter #(.WIDTH(CW), .LAST(N_BITS-1)) u_outer_ctr (
    .clk (clk),
    .rst (rst),
    .en  (st.step),
    .clr (st.setup),
    .cnt (outer_cnt),
    .tc  (tc_outer)
  );

  assign a_shift  = st.inner;
  assign sum_sel  = st.inner;
  assign b_shift  = st.step;
  assign lo_shift = st.step;
  assign step_clr = st.step;
  assign hi_shift = st.inner | st.step;

  // R4
  step_after_last_inner_chk: assert property (@(posedge clk) disable iff (rst)
    (st.inner && tc_inner) |=> (b_shift && !a_shift));

  // R3
  inner_fresh_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(a_shift)) |-> (inner_cnt == '0));

  // R6
  done_after_final_chk: assert property (@(posedge clk) disable iff (rst)
    (st.step && tc_outer) |=> done);

  // R5
  outer_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    st.setup |=> (outer_cnt == '0));

endmodule

// File: tb/serial_mult_sequencer_bench.sv
module serial_mult_sequencer_bench;

  localparam int NUM_CFG = 3;
  localparam int CFG_N [NUM_CFG] = '{2, 3, 5};
  // columns: accumulate, step, hi_shift, lo_shift, run length to done
  localparam int EXP [NUM_CFG][5] = '{
    '{4, 2, 6, 2, 8},
    '{9, 3, 12, 3, 14},
    '{25, 5, 30, 5, 32}
  };
  localparam int MAX_T = 36;
  // bit order: 0 a_shift,1 b_shift,2 hi_shift,3 lo_shift,4 sum_sel,5 step_clr,6 done
  localparam logic [6:0] V_ACC  = 7'b0010101;
  localparam logic [6:0] V_STEP = 7'b0101110;
  localparam logic [6:0] V_DONE = 7'b1000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [6:0] obs [NUM_CFG];

  int checks = 0;
  int errors = 0;
  int tally [NUM_CFG][7];

  always #4 clk = ~clk;

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_dut
    logic [6:0] o;
    serial_mult_sequencer #(.N_BITS(CFG_N[k])) u_serial_mult_sequencer (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .a_shift  (o[0]),
      .b_shift  (o[1]),
      .hi_shift (o[2]),
      .lo_shift (o[3]),
      .sum_sel  (o[4]),
      .step_clr (o[5]),
      .done     (o[6])
    );
    assign obs[k] = o;
  end

  task automatic chk(input string req, input int k, input int t,
                     input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s n=%0d t=%0d actual %b expected %b", req, CFG_N[k], t, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int k, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s n=%0d actual %0d expected %0d", req, CFG_N[k], act, exp);
    end
  endtask

  function automatic logic [6:0] expect_vec(input int n, input int len, input int tt);
    int pos;
    if (tt == len) return V_DONE;
    if (tt >= 2 && tt < len) begin
      pos = (tt - 2) % (n + 1);
      return (pos < n) ? V_ACC : V_STEP;
    end
    return 7'b0;
  endfunction

  function automatic string tag_for(input int n, input int len, input int tt);
    if (tt == 1) return "R2";
    if (tt == len) return "R6";
    if (tt > len) return "R1";
    if (((tt - 2) % (n + 1)) < n) return "R3";
    return "R4";
  endfunction

  task automatic run_seq(input bit hold, input bit count);
    @(negedge clk);
    start = 1'b1;
    for (int t = 1; t <= MAX_T; t++) begin
      @(negedge clk);
      if (!hold) start = 1'b0;
      for (int k = 0; k < NUM_CFG; k++) begin
        int len;
        int tt;
        string tag;
        len = EXP[k][4];
        tt  = hold ? ((t - 1) % len) + 1 : t;
        tag = hold ? ((t > len) ? "R8" : "R7") : tag_for(CFG_N[k], len, tt);
        chk(tag, k, t, obs[k], expect_vec(CFG_N[k], len, tt));
        chk("R10", k, t, {6'b0, obs[k][0] & obs[k][1]}, 7'b0);
        if (count)
          for (int b = 0; b < 7; b++) tally[k][b] += int'(obs[k][b]);
      end
    end
    start = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NUM_CFG; k++)
      for (int b = 0; b < 7; b++) tally[k][b] = 0;

    // R1: reset state and quiet idle
    repeat (3) @(negedge clk);
    for (int k = 0; k < NUM_CFG; k++) chk("R1", k, 0, obs[k], 7'b0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < NUM_CFG; k++) chk("R1", k, 0, obs[k], 7'b0);

    // table walk: full operation per width, with strobe totals
    run_seq(1'b0, 1'b1);
    for (int k = 0; k < NUM_CFG; k++) begin
      chk_int("R5 accumulate", k, tally[k][0], EXP[k][0]);
      chk_int("R5 sum_sel",    k, tally[k][4], EXP[k][0]);
      chk_int("R5 b_shift",    k, tally[k][1], EXP[k][1]);
      chk_int("R5 step_clr",   k, tally[k][5], EXP[k][1]);
      chk_int("R5 hi_shift",   k, tally[k][2], EXP[k][2]);
      chk_int("R5 lo_shift",   k, tally[k][3], EXP[k][3]);
      chk_int("R6 done count", k, tally[k][6], 1);
    end

    // R7 and R8: start held high through and past done
    run_seq(1'b1, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9: reset in the middle of an operation
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    for (int k = 0; k < NUM_CFG; k++) chk("R9", k, 0, obs[k], 7'b0);
    rst = 1'b0;
    repeat (3) begin
      @(negedge clk);
      for (int k = 0; k < NUM_CFG; k++) chk("R9", k, 0, obs[k], 7'b0);
    end

    // fresh operation after the abort
    run_seq(1'b0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule